// File: doc/BRIEF.md
# Multi-slot in-order retire queue

This block keeps track of in-flight instructions in program order and lets them leave in that same order. Each instruction arriving on the dispatch port claims a contiguous run of slots in a circular queue, one slot per micro-op. An instruction with no micro-ops still takes one slot, and a count larger than the queue is cut to the queue depth. The block answers with a token, which is the index of the first slot of that run. The execution units later give that token back on the completion port to mark the instruction as finished.

Each cycle the retire logic starts at the oldest entry. It retires consecutive finished entries, returns their slots to the free pool and moves the oldest-entry pointer forward by each entry's slot count. It stops at the first unfinished entry or at the per-cycle retire limit, whichever comes first. A limit of zero means there is no limit. The number of free slots is available on a port. Dispatch is refused whenever the run asked for does not fit in the free slots.

Top module: `slot_retire_queue`

## Requirements
- R1: After reset the free-slot count equals DEPTH, the dispatch token is 0 and no retire lane is valid.
- R2: A dispatch claims max(1, min(micro-op count, DEPTH)) slots and lowers the free-slot count by that amount.
- R3: The token given for a dispatch is the first slot of its run, and the next run starts at that index plus the claimed count, modulo DEPTH.
- R4: disp_ready is high exactly when the claimed count for the current disp_uops is not larger than the free-slot count. A dispatch while disp_ready is low is dropped.
- R5: A completion with a token marks that entry as finished. The entry can retire from the cycle after the completion.
- R6: Retirement is strictly in order. Nothing retires while the oldest entry is unfinished, even if younger entries have finished.
- R7: At most MAX_RETIRE entries retire per cycle, or up to the whole queue when MAX_RETIRE is 0. Retire lanes fill from lane 0 with no gaps.
- R8: The free-slot count changes each cycle by the slots of the retired entries minus the slots claimed by an accepted dispatch, and it returns to DEPTH when the queue drains.
- R9: Retired tags appear in dispatch order. Lane i of ret_tag sits in bits [i*TAG_W +: TAG_W], and lane 0 holds the oldest entry.
- R10: The head and tail indices wrap around the end of the queue correctly, including runs that span the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the dispatched instruction |
| disp_tag | input | TAG_W | Instruction tag stored with the entry |
| disp_ready | output | 1 | The requested run fits in the free slots |
| disp_token | output | IDX_W | First slot of the run being reserved |
| cmpl_valid | input | 1 | Execution-complete strobe |
| cmpl_token | input | IDX_W | Token of the finished instruction |
| ret_valid | output | LANES | Per-lane retire strobe, filled from lane 0 |
| ret_tag | output | LANES*TAG_W | Tags of the entries retired this cycle |
| free_slots | output | CNT_W | Number of unreserved slots |

## Verification
The assertions take as given that a completion names a token that is currently reserved and not yet finished, and that completions arrive only for tokens handed out on earlier cycles. The stimulus meets this by picking completions only from the bench's own list of outstanding unfinished entries, and it never repeats one. Dispatch requests may arrive when the queue is full, because the block refuses them itself. The bench drives such requests on purpose to check the stall.

// File: rtl/sq_pkg.sv
package sq_pkg;

   // Slots an instruction occupies: at least one, at most the whole ring.
   function automatic int unsigned slot_need(int unsigned uops, int unsigned depth);
      if (uops == 0) return 1;
      if (uops > depth) return depth;
      return uops;
   endfunction

   // Ring index advance for any depth; step never exceeds depth.
   function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                            int unsigned depth);
      int unsigned s;
      s = base + step;
      return (s >= depth) ? s - depth : s;
   endfunction

endpackage

// File: rtl/sq_alloc.sv
module sq_alloc
   import sq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int UOP_W = 5,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [UOP_W-1:0] disp_uops,
   input  logic [CNT_W-1:0] free_cnt,
   output logic             ready,
   output logic             fire,
   output logic [CNT_W-1:0] need,
   output logic [IDX_W-1:0] tail
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [IDX_W-1:0] tail_q;
   logic [IDX_W-1:0] tail_d;

   assign need  = CNT_W'(slot_need(32'(disp_uops), DEPTH));
   assign ready = need <= free_cnt;
   assign fire  = disp_valid && ready;
   assign tail  = tail_q;

   generate
      if (POW2) begin : g_mask_wrap
         assign tail_d = tail_q + IDX_W'(need);
      end else begin : g_cmp_wrap
         assign tail_d = IDX_W'(ring_add(32'(tail_q), 32'(need), DEPTH));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         tail_q <= '0;
      else if (fire)
         tail_q <= tail_d;
   end

   // R3
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (need != CNT_W'(DEPTH)) |=> tail_q != $past(tail_q));

endmodule

// File: rtl/sq_entry_store.sv
module sq_entry_store #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int TAG_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [CNT_W-1:0]            wr_cnt,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic                        set_en,
   input  logic [IDX_W-1:0]            set_idx,
   input  logic [DEPTH-1:0]            clr_vec,
   output logic [DEPTH-1:0]            busy,
   output logic [DEPTH-1:0]            done,
   output logic [DEPTH-1:0][CNT_W-1:0] cnt,
   output logic [DEPTH-1:0][TAG_W-1:0] tag
);

   genvar s;
   generate
      for (s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy[s] <= 1'b0;
               done[s] <= 1'b0;
               cnt[s]  <= '0;
               tag[s]  <= '0;
            end else begin
               if (clr_vec[s]) begin
                  busy[s] <= 1'b0;
                  done[s] <= 1'b0;
               end
               if (set_en && set_idx == IDX_W'(s))
                  done[s] <= 1'b1;
               if (wr_en && wr_idx == IDX_W'(s)) begin
                  busy[s] <= 1'b1;
                  done[s] <= 1'b0;
                  cnt[s]  <= wr_cnt;
                  tag[s]  <= wr_tag;
               end
            end
         end
      end
   endgenerate

   // R5
   cmpl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> busy[set_idx] && !done[set_idx]);

endmodule

// File: rtl/sq_retire_sel.sv
module sq_retire_sel
   import sq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int TAG_W = 8,
   parameter int LANES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CNT_W-1:0]            occ,
   input  logic [DEPTH-1:0]            busy,
   input  logic [DEPTH-1:0]            done,
   input  logic [DEPTH-1:0][CNT_W-1:0] cnt,
   input  logic [DEPTH-1:0][TAG_W-1:0] tag,
   output logic [LANES-1:0]            ret_valid,
   output logic [LANES*TAG_W-1:0]      ret_tag,
   output logic [DEPTH-1:0]            clr_vec,
   output logic [CNT_W-1:0]            ret_slots,
   output logic [IDX_W-1:0]            head
);

   logic [IDX_W-1:0] head_q;
   logic [IDX_W-1:0] walk_idx;
   int unsigned      used_v;
   logic             go_v;

   assign head = head_q;

   always_comb begin
      walk_idx  = head_q;
      used_v    = 0;
      go_v      = 1'b1;
      ret_valid = '0;
      ret_tag   = '0;
      clr_vec   = '0;
      for (int l = 0; l < LANES; l++) begin
         if (go_v && (used_v < 32'(occ)) && busy[walk_idx] && done[walk_idx]) begin
            ret_valid[l]             = 1'b1;
            ret_tag[l*TAG_W +: TAG_W] = tag[walk_idx];
            clr_vec[walk_idx]        = 1'b1;
            used_v                   = used_v + 32'(cnt[walk_idx]);
            walk_idx = IDX_W'(ring_add(32'(walk_idx), 32'(cnt[walk_idx]), DEPTH));
         end else begin
            go_v = 1'b0;
         end
      end
      ret_slots = CNT_W'(used_v);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         head_q <= '0;
      else
         head_q <= walk_idx;
   end

endmodule

// File: rtl/slot_retire_queue.sv
module slot_retire_queue #(
   parameter  int DEPTH      = 16,
   parameter  int UOP_W      = 5,
   parameter  int TAG_W      = 8,
   parameter  int MAX_RETIRE = 2,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CNT_W      = $clog2(DEPTH + 1),
   localparam int LANES      = (MAX_RETIRE == 0) ? DEPTH : MAX_RETIRE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   disp_valid,
   input  logic [UOP_W-1:0]       disp_uops,
   input  logic [TAG_W-1:0]       disp_tag,
   output logic                   disp_ready,
   output logic [IDX_W-1:0]       disp_token,
   input  logic                   cmpl_valid,
   input  logic [IDX_W-1:0]       cmpl_token,
   output logic [LANES-1:0]       ret_valid,
   output logic [LANES*TAG_W-1:0] ret_tag,
   output logic [CNT_W-1:0]       free_slots
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("slot_retire_queue: DEPTH must be at least 2");
      end
      if (MAX_RETIRE < 0 || MAX_RETIRE > DEPTH) begin : g_bad_limit
         $error("slot_retire_queue: MAX_RETIRE must lie in 0..DEPTH");
      end
      if (UOP_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("slot_retire_queue: UOP_W and TAG_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0]            free_q;
   logic                        fire;
   logic [CNT_W-1:0]            need;
   logic [IDX_W-1:0]            tail;
   logic [DEPTH-1:0]            busy;
   logic [DEPTH-1:0]            done;
   logic [DEPTH-1:0][CNT_W-1:0] cnt;
   logic [DEPTH-1:0][TAG_W-1:0] tag;
   logic [DEPTH-1:0]            clr_vec;
   logic [CNT_W-1:0]            ret_slots;
   logic [IDX_W-1:0]            head;
   logic [CNT_W-1:0]            occ;

   assign occ        = CNT_W'(DEPTH) - free_q;
   assign free_slots = free_q;
   assign disp_token = tail;

   sq_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_alloc (
      .clk        (clk),
      .rst_n      (rst_n),
      .disp_valid (disp_valid),
      .disp_uops  (disp_uops),
      .free_cnt   (free_q),
      .ready      (disp_ready),
      .fire       (fire),
      .need       (need),
      .tail       (tail)
   );

   sq_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fire),
      .wr_idx  (tail),
      .wr_cnt  (need),
      .wr_tag  (disp_tag),
      .set_en  (cmpl_valid),
      .set_idx (cmpl_token),
      .clr_vec (clr_vec),
      .busy    (busy),
      .done    (done),
      .cnt     (cnt),
      .tag     (tag)
   );

   sq_retire_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W),
                   .LANES(LANES)) u_retire (
      .clk       (clk),
      .rst_n     (rst_n),
      .occ       (occ),
      .busy      (busy),
      .done      (done),
      .cnt       (cnt),
      .tag       (tag),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .clr_vec   (clr_vec),
      .ret_slots (ret_slots),
      .head      (head)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         free_q <= CNT_W'(DEPTH);
      else
         free_q <= free_q + ret_slots - (fire ? need : '0);
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_q <= CNT_W'(DEPTH));

   // R8
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_q == CNT_W'(DEPTH)) |-> (busy == '0) && (ret_valid == '0));

   // R8
   retire_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_slots <= occ);

   // R10
   head_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_q != CNT_W'(DEPTH)) |-> busy[head]);

endmodule

// File: tb/test_slot_retire_queue.sv
module test_slot_retire_queue;

   localparam int DEPTH = 16;
   localparam int UOP_W = 5;
   localparam int TAG_W = 8;
   localparam int MAXR  = 2;
   localparam int IDX_W = 4;
   localparam int CNT_W = 5;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  disp_valid = 1'b0;
   logic [UOP_W-1:0]      disp_uops = '0;
   logic [TAG_W-1:0]      disp_tag = '0;
   logic                  disp_ready;
   logic [IDX_W-1:0]      disp_token;
   logic                  cmpl_valid = 1'b0;
   logic [IDX_W-1:0]      cmpl_token = '0;
   logic [MAXR-1:0]       ret_valid;
   logic [MAXR*TAG_W-1:0] ret_tag;
   logic [CNT_W-1:0]      free_slots;

   slot_retire_queue #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W), .MAX_RETIRE(MAXR))
   i_slot_retire_queue (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_uops(disp_uops),
      .disp_tag(disp_tag), .disp_ready(disp_ready), .disp_token(disp_token),
      .cmpl_valid(cmpl_valid), .cmpl_token(cmpl_token), .ret_valid(ret_valid),
      .ret_tag(ret_tag), .free_slots(free_slots)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // scoreboard: outstanding entries in dispatch order
   int m_tag [64];
   int m_slots [64];
   int m_tok [64];
   bit m_exec [64];
   int m_hd = 0;
   int m_cnt = 0;
   int m_tail = 0;
   int m_free = DEPTH;
   int tag_ctr = 1;

   function automatic int exp_need(int u);
      if (u == 0) return 1;
      if (u > DEPTH) return DEPTH;
      return u;
   endfunction

   function automatic int first_open();
      for (int k = 0; k < m_cnt; k++)
         if (!m_exec[(m_hd + k) % 64]) return k;
      return 0;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next one.
   task automatic step(bit dv, int du, bit cv, int coff);
      int need, nret, pos;
      bit exp_rdy, do_c;
      do_c = cv && (coff < m_cnt) && !m_exec[(m_hd + coff) % 64];
      pos = (m_hd + coff) % 64;
      disp_valid = dv;
      disp_uops  = UOP_W'(du);
      disp_tag   = TAG_W'(tag_ctr);
      cmpl_valid = do_c;
      cmpl_token = do_c ? IDX_W'(m_tok[pos]) : '0;
      #1;
      need = exp_need(du);
      exp_rdy = need <= m_free;
      check(disp_ready == exp_rdy, "R4 ready", int'(disp_ready), int'(exp_rdy));
      check(int'(free_slots) == m_free, "R8 free count", int'(free_slots), m_free);
      if (dv)
         check(int'(disp_token) == m_tail, "R3 R10 token", int'(disp_token), m_tail);
      nret = 0;
      while (nret < MAXR && nret < m_cnt && m_exec[(m_hd + nret) % 64]) nret++;
      for (int l = 0; l < MAXR; l++) begin
         check(ret_valid[l] == (l < nret), "R5 R6 R7 lane valid",
               int'(ret_valid[l]), int'(l < nret));
         if (l < nret)
            check(int'(ret_tag[l*TAG_W +: TAG_W]) == m_tag[(m_hd + l) % 64] % 256,
                  "R9 R10 tag order", int'(ret_tag[l*TAG_W +: TAG_W]),
                  m_tag[(m_hd + l) % 64] % 256);
      end
      if (do_c) m_exec[pos] = 1'b1;
      for (int k = 0; k < nret; k++) begin
         m_free += m_slots[m_hd];
         m_hd = (m_hd + 1) % 64;
         m_cnt--;
      end
      if (dv && exp_rdy) begin
         pos = (m_hd + m_cnt) % 64;
         m_tag[pos] = tag_ctr;
         m_slots[pos] = need;
         m_tok[pos] = m_tail;
         m_exec[pos] = 1'b0;
         m_cnt++;
         m_tail = (m_tail + need) % DEPTH;
         m_free -= need;
         tag_ctr++;
      end
      @(negedge clk);
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while ((m_cnt > 0 || m_free != DEPTH) && guard < 200) begin
         step(0, 0, 1, first_open());
         guard++;
      end
      step(0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(int'(free_slots) == DEPTH, "R1 free after reset", int'(free_slots), DEPTH);
      check(disp_token == '0, "R1 token after reset", int'(disp_token), 0);
      check(ret_valid == '0, "R1 no retire after reset", int'(ret_valid), 0);
      @(negedge clk);

      // R2 zero-micro-op entries take one slot each; fill the ring
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0);
      #1;
      check(int'(free_slots) == 0, "R2 zero-uop fill", int'(free_slots), 0);
      @(negedge clk);
      // R4 full-buffer stall
      step(1, 1, 0, 0);
      step(1, 0, 0, 0);

      // R6 younger entries finished, oldest not: nothing retires
      step(0, 0, 1, 3);
      step(0, 0, 1, 5);
      step(0, 0, 1, 4);
      step(0, 0, 0, 0);
      #1;
      check(ret_valid == '0, "R6 head blocks retire", int'(ret_valid), 0);
      @(negedge clk);
      drain();

      // R2 oversize count clamps to DEPTH; needs an empty ring
      step(1, 3, 0, 0);
      step(1, 31, 0, 0);
      drain();
      step(1, 31, 0, 0);
      #1;
      check(int'(free_slots) == 0, "R2 clamp to depth", int'(free_slots), 0);
      @(negedge clk);
      step(1, 0, 0, 0);
      drain();

      // R10 runs that straddle the wrap point
      for (int i = 0; i < 6; i++) begin
         step(1, 5, 0, 0);
         step(0, 0, 1, 0);
         step(0, 0, 0, 0);
      end
      drain();

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int du, co;
         bit dv, cv;
         dv = ($urandom % 3) != 0;
         du = (($urandom % 10) == 0) ? 20 : int'($urandom % 8);
         cv = (m_cnt > 0) && (($urandom % 4) != 0);
         co = (m_cnt > 0) ? int'($urandom % m_cnt) : 0;
         if (($urandom % 3) == 0) co = first_open();
         step(dv, du, cv, co);
      end
      drain();
      #1;
      check(int'(free_slots) == DEPTH, "R8 drained free count", int'(free_slots), DEPTH);

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule